// File: doc/BRIEF.md
# Multi-Range Auto-Reload Wakeup Timer

This block produces a periodic wakeup event for a real-time clock domain. A 16-bit reload value and a 3-bit tick-select field together set the wakeup interval. The tick is either the RTC clock divided by 2, 4, 8 or 16, or an external 1 Hz calendar tick. The down-counter reloads itself each time it wraps. On every wrap it sets a sticky flag, which can raise an interrupt and can also be driven onto an output pin with a chosen polarity.

The reload value and the tick select sit in shadow registers inside the block. They accept a write only while the timer is stopped and the write-allowed status is high. Setting the enable starts a new interval from the reload value. In the extended 1 Hz mode, 2^16 is added to the counter on that first load only. One 16-bit register therefore covers a 17-bit first interval.

Top module: `wkup_timer`

## Requirements
- R1: After reset the flag, interrupt and wakeup pulse are low, write-allowed is high, the reload register is 0 and the tick select is 000.
- R2: With tick select 000, 001, 010 or 011 the tick is the RTC clock divided by 16, 8, 4 or 2. The first wrap occurs div*(reload+1) clock cycles after the edge that samples enable high.
- R3: After a wrap the counter reloads from the reload register, so every later interval is the same length as the first.
- R4: With tick select 10x the counter steps once per cycle in which sec_tick_i is high, and an interval lasts reload+1 ticks.
- R5: With tick select 11x the first interval after enable lasts 65536+reload+1 ticks, and every later interval lasts reload+1 ticks.
- R6: Write-allowed rises on the second clock edge at which enable has been sampled low, and falls on the second clock edge at which enable has been sampled high.
- R7: A write strobe updates the reload and tick-select registers only when write-allowed is high and enable is low. Otherwise the write has no effect.
- R8: Setting enable again restarts counting from the reload value, whatever count had been reached before.
- R9: Each wrap sets the flag, and the flag stays set until flag_clr_i clears it. A wrap in the same cycle as a clear leaves the flag set.
- R10: The interrupt is high exactly when the flag is high and irq_en_i is high.
- R11: The pin is driven by the out-select field (out_sel_i): 11 gives a one-cycle wakeup pulse per wrap, 01 gives alarm_a_i, 10 gives alarm_b_i, and 00 gives a constant inactive level. Whatever is selected is XORed with out_pol_i, where 1 means active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RTC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Timer run enable |
| cfg_we_i | input | 1 | Write strobe for the reload and tick-select registers |
| cfg_reload_i | input | 16 | Reload value to write |
| cfg_sel_i | input | 3 | Tick select to write |
| sec_tick_i | input | 1 | 1 Hz calendar tick, one cycle wide |
| flag_clr_i | input | 1 | Clears the wakeup flag |
| irq_en_i | input | 1 | Interrupt enable |
| out_sel_i | input | 2 | Output pin source select |
| out_pol_i | input | 1 | Output polarity, 1 = active low |
| alarm_a_i | input | 1 | Alarm A event, routed when out_sel_i is 01 |
| alarm_b_i | input | 1 | Alarm B event, routed when out_sel_i is 10 |
| wr_ok_o | output | 1 | Configuration writes allowed |
| flag_o | output | 1 | Sticky wakeup flag |
| irq_o | output | 1 | Wakeup interrupt |
| wake_pin_o | output | 1 | Wakeup output pin |

## Verification
The bench measures the first interval and the interval between wraps in every divided mode. A wrong divider shows up as a scaled period. A counter that wraps at 1 instead of 0 shows up as a period that is one tick short.

In the extended mode the bench uses a small reload value and checks that the first interval is 65539 ticks and the next is 3. An offset that is reapplied on every reload would make the second interval long as well.

A reload write attempted while the timer runs must leave the interval unchanged. A re-enable partway through an interval must restart the full interval rather than resume the old count. The bench also checks that write-allowed changes on the second edge and not the first. It checks that the flag survives until it is cleared, and it walks the pin through each source select under both polarities.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned RLD_W = 16;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PRE_W = 4;
  localparam int unsigned CNT_W = RLD_W + 1;

  localparam logic [1:0] OSEL_OFF   = 2'b00;
  localparam logic [1:0] OSEL_ALM_A = 2'b01;
  localparam logic [1:0] OSEL_ALM_B = 2'b10;
  localparam logic [1:0] OSEL_WAKE  = 2'b11;

  // sel[2]=1: calendar tick; sel[1] then picks extended load
  function automatic logic sel_is_sec(input logic [SEL_W-1:0] s);
    return s[2];
  endfunction

  function automatic logic sel_is_ext(input logic [SEL_W-1:0] s);
    return s[2] & s[1];
  endfunction
endpackage

// File: rtl/wkup_tick_gen.sv
module wkup_tick_gen
  import wkup_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sec_tick_i,
  output logic             tick_o
);
  logic [PW-1:0] pre_q;
  logic          tick_div;
  logic [2:0]    n_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (start_i) pre_q <= '0;
    else if (run_i)   pre_q <= pre_q + 1'b1;
  end

  // sel[1:0]=00 -> all PW bits (/16), 11 -> 1 bit (/2)
  always_comb begin
    n_bits   = 3'(PW) - {1'b0, sel_i[1:0]};
    tick_div = 1'b1;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(n_bits)) tick_div = tick_div & pre_q[i];
    end
  end

  assign tick_o = sel_is_sec(sel_i) ? sec_tick_i : tick_div;
endmodule

// File: rtl/wkup_down_cnt.sv
module wkup_down_cnt
  import wkup_pkg::*;
#(
  parameter int unsigned RW = RLD_W,
  localparam int unsigned CW = RW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          ext_i,
  input  logic [RW-1:0] reload_i,
  output logic          wrap_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = run_i & tick_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= {ext_i, reload_i};
    else if (wrap_o)        cnt_q <= {1'b0, reload_i};
    else if (run_i && tick_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wkup_out.sv
module wkup_out
  import wkup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wrap_i,
  input  logic       flag_clr_i,
  input  logic       irq_en_i,
  input  logic [1:0] out_sel_i,
  input  logic       out_pol_i,
  input  logic       alarm_a_i,
  input  logic       alarm_b_i,
  output logic       flag_o,
  output logic       irq_o,
  output logic       pulse_o,
  output logic       pin_o
);
  logic flag_q, pulse_q, src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap_i;
      if (wrap_i)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (out_sel_i)
      OSEL_WAKE:  src = pulse_q;
      OSEL_ALM_A: src = alarm_a_i;
      OSEL_ALM_B: src = alarm_b_i;
      default:    src = 1'b0;
    endcase
  end

  assign flag_o  = flag_q;
  assign irq_o   = flag_q & irq_en_i;
  assign pulse_o = pulse_q;
  assign pin_o   = src ^ out_pol_i;
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
  import wkup_pkg::*;
#(
  parameter int unsigned RW = RLD_W,
  parameter int unsigned PW = PRE_W,
  localparam int unsigned CW = RW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cfg_we_i,
  input  logic [RW-1:0]    cfg_reload_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic             sec_tick_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic [1:0]       out_sel_i,
  input  logic             out_pol_i,
  input  logic             alarm_a_i,
  input  logic             alarm_b_i,
  output logic             wr_ok_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_pin_o
);
  logic             run_q, wr_ok_q, start, tick, wrap, pulse;
  logic [RW-1:0]    reload_q;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt;

  assign start = enable_i & ~run_q;

  // two-stage handshake for the write-allowed status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      wr_ok_q <= 1'b1;
    end else begin
      run_q   <= enable_i;
      wr_ok_q <= ~run_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      sel_q    <= '0;
    end else if (cfg_we_i && wr_ok_q && !enable_i) begin
      reload_q <= cfg_reload_i;
      sel_q    <= cfg_sel_i;
    end
  end

  wkup_tick_gen #(.PW(PW)) u_tick (
    .clk_i, .rst_ni, .run_i(run_q), .start_i(start), .sel_i(sel_q),
    .sec_tick_i, .tick_o(tick)
  );

  wkup_down_cnt #(.RW(RW)) u_cnt (
    .clk_i, .rst_ni, .start_i(start), .run_i(run_q), .tick_i(tick),
    .ext_i(sel_is_ext(sel_q)), .reload_i(reload_q), .wrap_o(wrap), .cnt_o(cnt)
  );

  wkup_out u_out (
    .clk_i, .rst_ni, .wrap_i(wrap), .flag_clr_i, .irq_en_i, .out_sel_i,
    .out_pol_i, .alarm_a_i, .alarm_b_i, .flag_o, .irq_o, .pulse_o(pulse),
    .pin_o(wake_pin_o)
  );

  assign wr_ok_o = wr_ok_q;
endmodule

// File: rtl/wkup_timer_chk.sv
module wkup_timer_chk #(
  parameter int unsigned CW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          flag_clr_i,
  input logic          wr_ok_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic          irq_en_i,
  input logic [1:0]    out_sel_i,
  input logic          out_pol_i,
  input logic          wake_pin_o,
  input logic          wrap,
  input logic          pulse,
  input logic [CW-1:0] cnt
);
  assert_wrap_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_o);
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));
  assert_wr_ok_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !$past(enable_i)) |=> wr_ok_o);
  assert_wr_ok_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i)) |=> !wr_ok_o);
  assert_stopped_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o && !enable_i) |=> $stable(cnt));
  assert_pulse_from_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |-> $past(wrap));
  assert_off_inactive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_i == 2'b00) |-> (wake_pin_o == out_pol_i));
endmodule

bind wkup_timer wkup_timer_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .enable_i, .flag_clr_i, .wr_ok_o, .flag_o, .irq_o, .irq_en_i,
  .out_sel_i, .out_pol_i, .wake_pin_o, .wrap, .pulse, .cnt
);

// File: tb/wkup_timer_bench.sv
module wkup_timer_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        enable = 0, cfg_we = 0, sec_tick = 0, flag_clr = 0, irq_en = 0;
  logic [15:0] cfg_reload = '0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  out_sel = 2'b11;
  logic        out_pol = 0, alarm_a = 0, alarm_b = 0;
  logic        wr_ok, flag, irq, pin;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  wkup_timer u_wkup_timer (
    .clk_i(clk), .rst_ni, .enable_i(enable), .cfg_we_i(cfg_we),
    .cfg_reload_i(cfg_reload), .cfg_sel_i(cfg_sel), .sec_tick_i(sec_tick),
    .flag_clr_i(flag_clr), .irq_en_i(irq_en), .out_sel_i(out_sel),
    .out_pol_i(out_pol), .alarm_a_i(alarm_a), .alarm_b_i(alarm_b),
    .wr_ok_o(wr_ok), .flag_o(flag), .irq_o(irq), .wake_pin_o(pin)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts edges until the wake pulse (active high, sel 11) is seen
  task automatic wait_pulse(output int n, input int lim);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!pin && n < lim);
  endtask

  task automatic stop_and_cfg(input logic [2:0] s, input logic [15:0] r);
    @(negedge clk); enable = 0;
    repeat (3) @(negedge clk);
    cfg_sel = s; cfg_reload = r; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wr_ok", wr_ok, 1);
    chk("R1 pin", pin, 0);
  endtask

  // R2 first interval, R3 later interval
  task automatic t_divided(input logic [2:0] s, input int r);
    int n, div;
    div = 16 >> s[1:0];
    stop_and_cfg(s, 16'(r));
    out_sel = 2'b11; out_pol = 0;
    enable = 1;
    wait_pulse(n, 5000);
    chk("R2 first period", n - 1, div * (r + 1));
    chk("R9 flag set", flag, 1);
    @(posedge clk); @(negedge clk);
    chk("R11 one-cycle pulse", pin, 0);
    wait_pulse(n, 5000);
    chk("R3 reload period", n + 1, div * (r + 1));
  endtask

  task automatic t_sec(input logic [2:0] s, input int r, input int first);
    int n;
    stop_and_cfg(s, 16'(r));
    sec_tick = 1;
    enable = 1;
    wait_pulse(n, 70000);
    chk(s[1] ? "R5 extended first" : "R4 sec first", n - 1, first);
    wait_pulse(n, 70000);
    chk(s[1] ? "R5 extended reload" : "R4 sec reload", n, r + 1);
    sec_tick = 0;
  endtask

  task automatic t_wr_ok();
    @(negedge clk); enable = 1;
    @(negedge clk); chk("R6 still high after 1 edge", wr_ok, 1);
    @(negedge clk); chk("R6 low after 2 edges", wr_ok, 0);
    enable = 0;
    @(negedge clk); chk("R6 still low after 1 edge", wr_ok, 0);
    @(negedge clk); chk("R6 high after 2 edges", wr_ok, 1);
  endtask

  task automatic t_lock();
    int n;
    stop_and_cfg(3'b011, 16'd3);
    enable = 1;
    wait_pulse(n, 1000);
    cfg_reload = 16'd9; cfg_sel = 3'b000; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
    wait_pulse(n, 1000);
    chk("R7 write while running ignored", n + 1, 8);
  endtask

  task automatic t_restart();
    int n;
    stop_and_cfg(3'b010, 16'd5);
    enable = 1;
    repeat (13) @(negedge clk);
    enable = 0;
    @(negedge clk); enable = 1;
    wait_pulse(n, 1000);
    chk("R8 restart full interval", n - 1, 24);
  endtask

  task automatic t_flag_irq();
    stop_and_cfg(3'b011, 16'd0);
    enable = 1;
    repeat (4) @(negedge clk);
    enable = 0;
    repeat (3) @(negedge clk);
    irq_en = 0;
    chk("R10 irq masked", irq, 0);
    chk("R9 flag held", flag, 1);
    irq_en = 1; #1;
    chk("R10 irq on", irq, 1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk("R9 flag cleared", flag, 0);
    chk("R10 irq off", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_pin();
    @(negedge clk);
    out_sel = 2'b01; alarm_a = 1; alarm_b = 0; out_pol = 0; #1;
    chk("R11 alarm a", pin, 1);
    out_pol = 1; #1;
    chk("R11 alarm a low-active", pin, 0);
    out_sel = 2'b10; #1;
    chk("R11 alarm b", pin, 1);
    alarm_b = 1; #1;
    chk("R11 alarm b active", pin, 0);
    out_sel = 2'b00; #1;
    chk("R11 off inactive", pin, 1);
    out_sel = 2'b11; #1;
    chk("R11 wake idle inactive", pin, 1);
    out_pol = 0; alarm_a = 0; alarm_b = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_wr_ok();
    t_divided(3'b000, 2);
    t_divided(3'b001, 4);
    t_divided(3'b010, 3);
    t_divided(3'b011, 6);
    t_sec(3'b100, 4, 5);
    t_sec(3'b110, 2, 65539);
    t_lock();
    t_restart();
    t_flag_irq();
    t_pin();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule